// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller. With its default parameters it serves 64 pins, grouped into two 32-bit words. A host reaches it through a plain register port: a byte address, a write strobe, write data, and read data that follows the address combinationally. Each pin carries three signals: an input, an output and an output enable.

For every pin, software can choose the direction and drive an output latch. The latch is never written directly. It changes only through a set register and a clear register, so one pin can be altered without a read-modify-write. Software can also read the pin level after synchronization. It can arm rising-edge detection, falling-edge detection, or both. A sticky status bit records each qualifying edge, and all status bits are combined into a single interrupt line.

The register port accepts one access per cycle and applies no back-pressure. A write takes effect at the clock edge on which `wr_en` is sampled high. The pin signals are plain levels with no handshake.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register word reads 0. `pin_oe` and `irq` are low, so every pin starts as an input.
- R2: Word `w` of register kind `k` sits at byte offset `4*(k*NW + w)`, where NW is the number of words (2 by default). The kind order is: level=0, direction=1, set=2, clear=3, rise-enable=4, fall-enable=5, status=6. Pin n is bit n%32 of word n/32. An address past the last word reads 0, and writing to it changes nothing.
- R3: The level register returns `pin_i` after a two-flop synchronizer. A change driven just before a clock edge becomes readable after the second rising edge, and not after the first.
- R4: A direction bit of 1 raises that pin's `pin_oe`, and 0 lowers it. The direction register reads back the value written.
- R5: Each 1 bit written to the set register drives that pin's output latch high, and 0 bits leave the latch alone. `pin_o` shows the latch. Reading either the set or the clear offset returns the latch.
- R6: Each 1 bit written to the clear register drives that pin's output latch low, and 0 bits leave the latch alone.
- R7: The output latch keeps its value while the pin is an input, and can be loaded before the pin is switched to an output.
- R8: With its rise-enable bit at 1, a 0-to-1 change on a pin sets that pin's status bit. With its fall-enable bit at 1, a 1-to-0 change does the same. An edge on a pin without the matching enable sets nothing. The status bit is set on the third rising clock edge after the input changes.
- R9: With both enable bits at 1, either edge direction sets the status bit.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it as it was.
- R11: If a new edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R12: `irq` is high exactly when at least one status bit in any word is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address of the register word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WORD_W | Write data |
| rd_data | output | WORD_W | Read data for `addr`, combinational |
| pin_i | input | NUM_PINS | Pin input levels |
| pin_o | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables (direction bits) |
| irq | output | 1 | OR of all edge-status bits |

## Verification
The bench uses the default parameters: 64 pins, 32-bit words, two synchronizer stages and an 8-bit address. Two words per register kind bring the word-interleaved address map into reach. They also allow a check that an edge on pin 63 lands in the second status word only and still raises the shared interrupt. The bench models a pad that loops `pin_o` back to `pin_i` on output pins, so edges can be made both from outside and through the set and clear registers. The two-stage synchronizer makes the exact edge-to-status latency observable cycle by cycle, and it also lets the bench line up a clearing write with a new edge on the same bit.

// File: rtl/gpio_ec_pkg.sv
package gpio_ec_pkg;

  // Register kinds. The numeric order fixes the address map.
  typedef enum logic [2:0] {
    RK_LEVEL = 3'd0,
    RK_DIR   = 3'd1,
    RK_SET   = 3'd2,
    RK_CLR   = 3'd3,
    RK_RISE  = 3'd4,
    RK_FALL  = 3'd5,
    RK_STAT  = 3'd6
  } reg_kind_e;

  localparam int unsigned KIND_COUNT = 7;

  // Per-word write strobes produced by the decoder.
  typedef struct packed {
    logic dir;
    logic set;
    logic clr;
    logic rise;
    logic fall;
    logic stat;
  } wr_sel_t;

endpackage

// File: rtl/gpio_ec_sync.sv
module gpio_ec_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_ec_decode.sv
module gpio_ec_decode
  import gpio_ec_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NW     = 2,
  parameter int unsigned WIDX_W = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output reg_kind_e         kind_o,
  output logic [WIDX_W-1:0] word_o,
  output logic              valid_o,
  output wr_sel_t           sel_o [NW]
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic [1:0]       unused_lsb;
  int unsigned      widx_i;
  int unsigned      kind_i;
  int unsigned      word_i;

  assign widx       = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];

  always_comb begin
    widx_i = 32'(widx);
    kind_i = widx_i / NW;
    word_i = widx_i % NW;
  end

  assign kind_o  = reg_kind_e'(kind_i[2:0]);
  assign word_o  = word_i[WIDX_W-1:0];
  assign valid_o = (kind_i < KIND_COUNT);

  for (genvar w = 0; w < int'(NW); w++) begin : g_sel
    logic hit;
    assign hit = wr_en && valid_o && (word_i == w);
    always_comb begin
      sel_o[w]      = '0;
      sel_o[w].dir  = hit && (kind_o == RK_DIR);
      sel_o[w].set  = hit && (kind_o == RK_SET);
      sel_o[w].clr  = hit && (kind_o == RK_CLR);
      sel_o[w].rise = hit && (kind_o == RK_RISE);
      sel_o[w].fall = hit && (kind_o == RK_FALL);
      sel_o[w].stat = hit && (kind_o == RK_STAT);
    end
  end

endmodule

// File: rtl/gpio_ec_bank.sv
module gpio_ec_bank
  import gpio_ec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_sel_t      sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] stat_q
);

  logic [W-1:0] prev_q;
  logic [W-1:0] rise_hit;
  logic [W-1:0] fall_hit;
  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;
  logic [W-1:0] ack_mask;

  // Edge found by comparing the synchronized value with last cycle's.
  assign rise_hit = pin_sync & ~prev_q & rise_q;
  assign fall_hit = ~pin_sync & prev_q & fall_q;

  assign set_mask = sel.set  ? wr_data : '0;
  assign clr_mask = sel.clr  ? wr_data : '0;
  assign ack_mask = sel.stat ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      if (sel.dir)  dir_q  <= wr_data;
      if (sel.rise) rise_q <= wr_data;
      if (sel.fall) fall_q <= wr_data;
      out_q  <= (out_q | set_mask) & ~clr_mask;
      // A fresh edge outranks an acknowledge on the same bit.
      stat_q <= (stat_q & ~ack_mask) | rise_hit | fall_hit;
      prev_q <= pin_sync;
    end
  end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_ec_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 64,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  localparam int unsigned NW     = NUM_PINS / WORD_W;
  localparam int unsigned WIDX_W = (NW > 1) ? $clog2(NW) : 1;

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] sts_all;

  reg_kind_e         dec_kind;
  logic [WIDX_W-1:0] dec_word;
  logic              dec_valid;
  wr_sel_t           dec_sel [NW];

  logic [WORD_W-1:0] lvl_w  [NW];
  logic [WORD_W-1:0] dir_w  [NW];
  logic [WORD_W-1:0] out_w  [NW];
  logic [WORD_W-1:0] rise_w [NW];
  logic [WORD_W-1:0] fall_w [NW];
  logic [WORD_W-1:0] stat_w [NW];

  gpio_ec_sync #(
    .W      (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_i),
    .q     (pin_sync)
  );

  gpio_ec_decode #(
    .ADDR_W (ADDR_W),
    .NW     (NW),
    .WIDX_W (WIDX_W)
  ) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .kind_o  (dec_kind),
    .word_o  (dec_word),
    .valid_o (dec_valid),
    .sel_o   (dec_sel)
  );

  for (genvar w = 0; w < int'(NW); w++) begin : g_bank
    assign lvl_w[w] = pin_sync[w*WORD_W +: WORD_W];

    gpio_ec_bank #(
      .W (WORD_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (dec_sel[w]),
      .wr_data  (wr_data),
      .pin_sync (lvl_w[w]),
      .dir_q    (dir_w[w]),
      .out_q    (out_w[w]),
      .rise_q   (rise_w[w]),
      .fall_q   (fall_w[w]),
      .stat_q   (stat_w[w])
    );

    assign pin_oe [w*WORD_W +: WORD_W] = dir_w[w];
    assign pin_o  [w*WORD_W +: WORD_W] = out_w[w];
    assign sts_all[w*WORD_W +: WORD_W] = stat_w[w];
  end

  assign irq = |sts_all;

  always_comb begin
    rd_data = '0;
    if (dec_valid) begin
      unique case (dec_kind)
        RK_LEVEL:       rd_data = lvl_w[dec_word];
        RK_DIR:         rd_data = dir_w[dec_word];
        RK_SET, RK_CLR: rd_data = out_w[dec_word];
        RK_RISE:        rd_data = rise_w[dec_word];
        RK_FALL:        rd_data = fall_w[dec_word];
        RK_STAT:        rd_data = stat_w[dec_word];
        default:        rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic [WORD_W-1:0]   wr_data,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [NUM_PINS-1:0] sts_all
);

  localparam int unsigned NW = NUM_PINS / WORD_W;
  localparam logic [ADDR_W-1:0] DIR0 = ADDR_W'(1 * NW * 4);
  localparam logic [ADDR_W-1:0] SET0 = ADDR_W'(2 * NW * 4);
  localparam logic [ADDR_W-1:0] CLR0 = ADDR_W'(3 * NW * 4);
  localparam int unsigned STAT_LO = 6 * NW;
  localparam int unsigned STAT_HI = 7 * NW;

  logic is_stat;
  assign is_stat = (32'(addr[ADDR_W-1:2]) >= STAT_LO) && (32'(addr[ADDR_W-1:2]) < STAT_HI);

  // R1: coming out of reset, no pin drives and no interrupt is pending
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == 1'b0 && pin_oe == '0));

  // R4: a direction write shows up on the enables one cycle later
  a_r4_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DIR0) |=> (pin_oe[WORD_W-1:0] == $past(wr_data)));

  // R5: set bits force the latch high
  a_r5_set_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SET0) |=> ((pin_o[WORD_W-1:0] & $past(wr_data)) == $past(wr_data)));

  // R6: clear bits force the latch low
  a_r6_clr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CLR0) |=> ((pin_o[WORD_W-1:0] & $past(wr_data)) == '0));

  // R10: status bits never drop without a write to a status word
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_stat) |=> ((sts_all & $past(sts_all)) == $past(sts_all)));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .WORD_W   (WORD_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .pin_o   (pin_o),
  .pin_oe  (pin_oe),
  .irq     (irq),
  .sts_all (sts_all)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [63:0] pin_i;
  logic [63:0] pin_o;
  logic [63:0] pin_oe;
  logic        irq;
  logic [63:0] ext;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     smp;

  always #2.5 clk = ~clk;

  // Pad model: output pins loop back, inputs come from outside.
  assign pin_i = (pin_oe & pin_o) | (~pin_oe & ext);

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_i   (pin_i),
    .pin_o   (pin_o),
    .pin_oe  (pin_oe),
    .irq     (irq)
  );

  task automatic tally(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ra(input int kind, input int word);
    return 8'((kind * 2 + word) * 4);
  endfunction

  // Driver tasks: called at a falling edge, return at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.exp = e; it.tag = tag;
    addr = a;
    sb_q.push_back(it);
    #1 -> smp;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected read values and compares.
  initial begin
    forever begin
      sb_item_t it;
      @(smp);
      it = sb_q.pop_front();
      tally(rd_data == it.exp, it.tag, 64'(rd_data), 64'(it.exp));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext = '0; addr = '0; wr_en = 1'b0; wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    tally(pin_oe == '0, "R1 pin_oe", pin_oe, 64'd0);
    tally(irq == 1'b0, "R1 irq", 64'(irq), 64'd0);
    for (int k = 0; k < 7; k++)
      for (int w = 0; w < 2; w++) rd(ra(k, w), 32'h0, "R1 register");
    rd(8'h38, 32'h0, "R2 unmapped read");

    // R5 / R6 / R7: latch via set and clear while pins are inputs
    wr(ra(2, 0), 32'hA5A5_0003);
    rd(ra(2, 0), 32'hA5A5_0003, "R5 set readback");
    tally(pin_o[31:0] == 32'hA5A5_0003, "R5 pin_o", 64'(pin_o[31:0]), 64'hA5A5_0003);
    tally(pin_oe == '0, "R7 still input", pin_oe, 64'd0);
    wr(ra(3, 0), 32'h0000_0001);
    rd(ra(3, 0), 32'hA5A5_0002, "R6 clear one bit");

    // R4 direction, R2 word 1 through the pad
    wr(ra(1, 1), 32'hFFFF_0000);
    rd(ra(1, 1), 32'hFFFF_0000, "R4 dir readback");
    tally(pin_oe[63:32] == 32'hFFFF_0000, "R4 pin_oe", 64'(pin_oe[63:32]), 64'hFFFF_0000);
    wr(ra(2, 1), 32'h1234_0000);
    idle(3);
    rd(ra(0, 1), 32'h1234_0000, "R2 level word1");

    // R3 synchronizer latency
    ext[31:0] = 32'h0F0F_0F0F;
    idle(1);
    rd(ra(0, 0), 32'h0000_0000, "R3 not after one edge");
    rd(ra(0, 0), 32'h0F0F_0F0F, "R3 after two edges");

    // R8 enables and latency
    wr(ra(4, 0), 32'h0000_00F0);
    wr(ra(5, 0), 32'h0000_0F00);
    rd(ra(6, 0), 32'h0, "R8 no edge yet");
    ext[31:0] = 32'h0F0F_F0F0;
    idle(2);
    tally(irq == 1'b0, "R8 irq before third edge", 64'(irq), 64'd0);
    idle(1);
    tally(irq == 1'b1, "R12 irq on third edge", 64'(irq), 64'd1);
    rd(ra(6, 0), 32'h0000_0FF0, "R8 enabled edges only");

    // R9 both edges on pin 20
    wr(ra(4, 0), 32'h0010_00F0);
    wr(ra(5, 0), 32'h0010_0F00);
    ext[20] = 1'b1;
    idle(4);
    rd(ra(6, 0), 32'h0010_0FF0, "R9 rise");
    wr(ra(6, 0), 32'h0010_0000);
    rd(ra(6, 0), 32'h0000_0FF0, "R10 clear one");
    ext[20] = 1'b0;
    idle(4);
    rd(ra(6, 0), 32'h0010_0FF0, "R9 fall");

    // R10 write-one-to-clear
    wr(ra(6, 0), 32'h0);
    rd(ra(6, 0), 32'h0010_0FF0, "R10 zero write");
    wr(ra(6, 0), 32'h0000_00F0);
    rd(ra(6, 0), 32'h0010_0F00, "R10 partial clear");
    wr(ra(6, 0), 32'hFFFF_FFFF);
    rd(ra(6, 0), 32'h0, "R10 full clear");
    tally(irq == 1'b0, "R12 irq low", 64'(irq), 64'd0);

    // R8 / R12 word 1, pin 63 driven through the latch
    wr(ra(5, 1), 32'h8000_0000);
    wr(ra(2, 1), 32'h8000_0000);
    idle(4);
    rd(ra(6, 1), 32'h0, "R8 disabled rise");
    wr(ra(3, 1), 32'h8000_0000);
    idle(4);
    rd(ra(6, 1), 32'h8000_0000, "R8 word1 fall");
    rd(ra(6, 0), 32'h0, "R2 word0 untouched");
    tally(irq == 1'b1, "R12 irq from word1", 64'(irq), 64'd1);
    wr(ra(6, 1), 32'h8000_0000);
    tally(irq == 1'b0, "R12 irq cleared", 64'(irq), 64'd0);

    // R11 edge and clear in the same cycle on pin 5
    ext[5] = 1'b0;
    idle(4);
    rd(ra(6, 0), 32'h0, "R8 pin5 fall disabled");
    ext[5] = 1'b1;
    idle(2);
    wr(ra(6, 0), 32'h0000_0020);
    rd(ra(6, 0), 32'h0000_0020, "R11 edge wins");
    wr(ra(6, 0), 32'h0000_0020);
    rd(ra(6, 0), 32'h0, "R10 clear after collision");

    // R7 latch kept when switching back to input
    wr(ra(1, 1), 32'h0);
    tally(pin_oe == '0, "R4 all inputs", pin_oe, 64'd0);
    rd(ra(2, 1), 32'h1234_0000, "R7 latch kept");
    tally(pin_o[63:32] == 32'h1234_0000, "R7 pin_o kept", 64'(pin_o[63:32]), 64'h1234_0000);

    // R2 unmapped write ignored
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, 32'h0, "R2 unmapped write");
    rd(ra(1, 0), 32'h0, "R2 dir untouched");

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule